// File: doc/BRIEF.md
# Measurement FIFO with Parallel-Port Readout

This block sits between a pulse-interval measurement engine and a host parallel port. The engine hands over 32-bit interval words through a valid/ready pair. The block keeps up to four of them in a 16-byte buffer, so a burst of closely spaced measurements survives while the slower host link catches up. The host drains the buffer one byte per data-read cycle. Each cycle uses a strobe/wait handshake, and all strobes are resynchronized into the block clock before use.

Address cycles have two uses. An address write picks which register later data cycles reach: the measurement buffer or a loopback test register. An address read returns a status byte. That byte holds the buffer fill level and flags for refused measurements and empty reads. The host writes a byte to the test register and reads it back inverted. This shows that both directions of the bus are wired correctly before measurement starts.

Top module: `meas_epp_fifo`

## Requirements
- R1: `in_ready` is high exactly when fewer than four words are stored, and a word is stored on a clock edge where `in_valid` and `in_ready` are both high.
- R2: Data reads of register 0 return each stored word as four bytes, least significant byte first, words in arrival order. The fill level drops only when the fourth byte of a word is read.
- R3: After a strobe (`data_strobe_n` or `addr_strobe_n`) falls, `host_wait` rises on the third rising clock edge and not before. On a read (`host_write_n` high), `bus_oe` rises on that same edge and `bus_out` carries the reply. On the third rising edge after the strobe returns high, `host_wait` and `bus_oe` both fall.
- R4: An address read returns a status byte laid out as follows. Bits 2:0 hold the number of stored words. Bit 3 is set when four words are stored. Bit 4 is set once any word has been refused since reset. Bit 5 is set when a word was refused since the last status read. Bit 6 is set when an empty data read happened since the last status read. Bit 7 is 0.
- R5: A word offered while four are stored is dropped, leaves the stored words unchanged, and sets status bits 4 and 5.
- R6: A status read reports bits 5 and 6 as they were before the read, then clears them. Bit 4 is never cleared except by reset.
- R7: A data read of register 0 while the buffer is empty returns 0x00, leaves the fill level at 0, and sets status bit 6.
- R8: An address write uses bit 0 of `bus_in` to select the target of data cycles: 0 selects the measurement buffer and 1 selects the test register.
- R9: A data write with the test register selected stores `bus_in`. A data read with it selected returns the bitwise inverse of the stored byte and leaves the buffer untouched. After reset the stored byte is 0x00, so the read returns 0xFF.
- R10: A data write while the measurement buffer is selected has no effect on the stored words or on the fill level.
- R11: After reset, `in_ready` is 1, `host_wait` and `bus_oe` are 0, and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Measurement word offered |
| in_data | input | 32 | Measurement word |
| in_ready | output | 1 | Buffer can take a word |
| host_write_n | input | 1 | Host cycle direction, low for a write |
| data_strobe_n | input | 1 | Host data cycle strobe, active low |
| addr_strobe_n | input | 1 | Host address cycle strobe, active low |
| bus_in | input | 8 | Byte driven by the host |
| bus_out | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Block drives the bus |
| host_wait | output | 1 | Handshake reply to the host strobe |

## Verification
Suppose a read pointer or byte index goes wrong. The very next data read then returns a byte out of least-significant-first order. Suppose the fill counter drifts. `in_ready` then disagrees with the reference on the same clock, and the next status read shows a wrong count or full flag. Sticky flags that are lost or cleared at the wrong time appear at the next address read. A slip in the synchronizer or edge logic shows up within three clocks of a strobe change, because `host_wait` is checked both one edge before and at the expected edge.

// File: rtl/mef_pkg.sv
package mef_pkg;
  typedef enum logic {
    SEL_FIFO = 1'b0,
    SEL_TEST = 1'b1
  } reg_sel_e;

  localparam int ST_FULL  = 3;
  localparam int ST_OVF   = 4;
  localparam int ST_LOST  = 5;
  localparam int ST_UNDER = 6;
endpackage

// File: rtl/mef_strobe_sync.sv
module mef_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);
  // pipe[0] is the first capture stage; pipe[STAGES] holds the previous synced level
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], strobe_n};
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
  assign rise = ~pipe[STAGES] & pipe[STAGES-1];
endmodule

// File: rtl/mef_word_fifo.sv
module mef_word_fifo #(
  parameter int WORD_BYTES = 4,
  parameter int DEPTH      = 4,
  localparam int W  = 8 * WORD_BYTES,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          drop,
  input  logic          rd_byte,
  output logic [7:0]    byte_out,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [BW-1:0] byte_idx;
  logic [W-1:0]  head;
  logic          push, pop, step;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = ~full;
  assign drop     = in_valid & full;
  assign push     = in_valid & ~full;
  assign step     = rd_byte & ~empty;
  assign pop      = step & (byte_idx == BW'(WORD_BYTES - 1));

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_comb begin
    head     = mem[rd_ptr];
    byte_out = head[int'(byte_idx) * 8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      byte_idx <= '0;
      count    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (step) byte_idx <= pop ? '0 : byte_idx + BW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + CW'(1)) ||
    ($past(count) == count + CW'(1)));

  p_refused_no_grow_r5: assert property (@(posedge clk) disable iff (rst)
    full |=> (count <= $past(count)));
endmodule

// File: rtl/mef_host_port.sv
module mef_host_port
  import mef_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ds_fall,
  input  logic          ds_rise,
  input  logic          as_fall,
  input  logic          as_rise,
  input  logic          host_write_n,
  input  logic [7:0]    bus_in,
  input  logic [7:0]    fifo_byte,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  input  logic [CW-1:0] fifo_count,
  input  logic          fifo_drop,
  output logic          rd_byte,
  output logic          host_wait,
  output logic [7:0]    bus_out,
  output logic          bus_oe
);
  reg_sel_e   sel;
  logic [7:0] test_q;
  logic       ovf_ever, lost_q, under_q;
  logic       status_rd, under_set;
  logic [7:0] status;
  logic [7:0] data_reply;

  assign rd_byte   = ds_fall & host_write_n & (sel == SEL_FIFO);
  assign under_set = rd_byte & fifo_empty;
  assign status_rd = as_fall & host_write_n;

  always_comb begin
    status           = '0;
    status[2:0]      = 3'(fifo_count);
    status[ST_FULL]  = fifo_full;
    status[ST_OVF]   = ovf_ever;
    status[ST_LOST]  = lost_q;
    status[ST_UNDER] = under_q;
    if (sel == SEL_TEST)  data_reply = ~test_q;
    else if (fifo_empty)  data_reply = 8'h00;
    else                  data_reply = fifo_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= SEL_FIFO;
      test_q    <= '0;
      ovf_ever  <= 1'b0;
      lost_q    <= 1'b0;
      under_q   <= 1'b0;
      host_wait <= 1'b0;
      bus_oe    <= 1'b0;
      bus_out   <= '0;
    end else begin
      ovf_ever <= ovf_ever | fifo_drop;
      lost_q   <= fifo_drop | (lost_q & ~status_rd);
      under_q  <= under_set | (under_q & ~status_rd);
      if (ds_fall | as_fall) begin
        host_wait <= 1'b1;
        if (host_write_n) begin
          bus_oe  <= 1'b1;
          bus_out <= as_fall ? status : data_reply;
        end else if (as_fall) begin
          sel <= reg_sel_e'(bus_in[0]);
        end else if (sel == SEL_TEST) begin
          test_q <= bus_in;
        end
      end else if (ds_rise | as_rise) begin
        host_wait <= 1'b0;
        bus_oe    <= 1'b0;
        bus_out   <= '0;
      end
    end
  end

  p_wait_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (ds_fall || as_fall) |=> host_wait);

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    ((ds_rise || as_rise) && !ds_fall && !as_fall) |=> (!host_wait && !bus_oe));

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_ever |=> ovf_ever);

  p_lost_needs_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    lost_q |-> ovf_ever);
endmodule

// File: rtl/meas_epp_fifo.sv
module meas_epp_fifo #(
  parameter int WORD_BYTES  = 4,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int W  = 8 * WORD_BYTES,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         host_write_n,
  input  logic         data_strobe_n,
  input  logic         addr_strobe_n,
  input  logic [7:0]   bus_in,
  output logic [7:0]   bus_out,
  output logic         bus_oe,
  output logic         host_wait
);
  logic [1:0]    strobe_n, fall_v, rise_v;
  logic          rd_byte, f_empty, f_full, f_drop;
  logic [7:0]    f_byte;
  logic [CW-1:0] f_count;

  // index 0: data strobe, index 1: address strobe
  assign strobe_n = {addr_strobe_n, data_strobe_n};

  for (genvar gi = 0; gi < 2; gi++) begin : g_sync
    mef_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .strobe_n (strobe_n[gi]),
      .fall     (fall_v[gi]),
      .rise     (rise_v[gi])
    );
  end

  mef_word_fifo #(.WORD_BYTES(WORD_BYTES), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .drop     (f_drop),
    .rd_byte  (rd_byte),
    .byte_out (f_byte),
    .empty    (f_empty),
    .full     (f_full),
    .count    (f_count)
  );

  mef_host_port #(.CW(CW)) u_port (
    .clk          (clk),
    .rst          (rst),
    .ds_fall      (fall_v[0]),
    .ds_rise      (rise_v[0]),
    .as_fall      (fall_v[1]),
    .as_rise      (rise_v[1]),
    .host_write_n (host_write_n),
    .bus_in       (bus_in),
    .fifo_byte    (f_byte),
    .fifo_empty   (f_empty),
    .fifo_full    (f_full),
    .fifo_count   (f_count),
    .fifo_drop    (f_drop),
    .rd_byte      (rd_byte),
    .host_wait    (host_wait),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe)
  );
endmodule

// File: tb/meas_epp_fifo_tb.sv
module meas_epp_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        host_write_n = 1'b1;
  logic        data_strobe_n = 1'b1;
  logic        addr_strobe_n = 1'b1;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic        host_wait;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] q[$];
  int  m_idx = 0;
  bit  m_ovf = 0, m_lost = 0, m_under = 0, m_sel = 0;
  logic [7:0] m_test = 8'h00;

  always #2 clk = ~clk;

  meas_epp_fifo u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .host_write_n(host_write_n),
    .data_strobe_n(data_strobe_n), .addr_strobe_n(addr_strobe_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .host_wait(host_wait)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model: words accepted at the clock edge
  always @(posedge clk) begin
    if (!rst && in_valid) begin
      if (q.size() < 4) q.push_back(in_data);
      else begin m_ovf = 1; m_lost = 1; end
    end
  end

  // per-clock comparison of the ready flag (R1)
  always @(negedge clk) begin
    if (!rst && !done) chk(in_ready == (q.size() < 4), "R1 in_ready", {31'b0, in_ready}, {31'b0, q.size() < 4});
  end

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    @(negedge clk); in_valid = 1'b0;
  endtask

  function automatic logic [7:0] model_status();
    int n = q.size();
    return {1'b0, m_under, m_lost, m_ovf, (n == 4), 3'(n)};
  endfunction

  // one host cycle; returns the byte seen while wait is high
  task automatic host_cycle(input bit is_addr, input bit is_wr, input logic [7:0] wd,
                            input string req, output logic [7:0] rd);
    logic [7:0] exp;
    @(negedge clk);
    host_write_n = ~is_wr; bus_in = wd;
    if (is_addr) addr_strobe_n = 1'b0; else data_strobe_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(host_wait == 1'b0, "R3 wait not early", {31'b0, host_wait}, 0);
    @(posedge clk);
    // model acts on the same edge as the block
    exp = 8'h00;
    if (is_addr && !is_wr) begin
      exp = model_status(); m_lost = 0; m_under = 0;
    end else if (is_addr) begin
      m_sel = wd[0];
    end else if (!is_wr && m_sel) begin
      exp = ~m_test;
    end else if (!is_wr) begin
      if (q.size() == 0) begin exp = 8'h00; m_under = 1; end
      else begin
        exp = q[0][m_idx*8 +: 8];
        m_idx++;
        if (m_idx == 4) begin m_idx = 0; void'(q.pop_front()); end
      end
    end else if (m_sel) begin
      m_test = wd;
    end
    @(negedge clk);
    chk(host_wait == 1'b1, "R3 wait raised", {31'b0, host_wait}, 1);
    chk(bus_oe == !is_wr, "R3 bus_oe", {31'b0, bus_oe}, {31'b0, !is_wr});
    rd = bus_out;
    if (!is_wr) chk(bus_out == exp, req, {24'b0, bus_out}, {24'b0, exp});
    addr_strobe_n = 1'b1; data_strobe_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!host_wait && !bus_oe, "R3 release", {30'b0, host_wait, bus_oe}, 0);
    host_write_n = 1'b1;
  endtask

  task automatic rd_status(input string req);
    logic [7:0] d;
    host_cycle(1'b1, 1'b0, 8'h00, req, d);
  endtask

  task automatic rd_data(input string req);
    logic [7:0] d;
    host_cycle(1'b0, 1'b0, 8'h00, req, d);
  endtask

  task automatic wr_addr(input logic [7:0] v);
    logic [7:0] d;
    host_cycle(1'b1, 1'b1, v, "R8 select", d);
  endtask

  task automatic wr_data(input logic [7:0] v, input string req);
    logic [7:0] d;
    host_cycle(1'b0, 1'b1, v, req, d);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !host_wait && !bus_oe, "R11 reset outputs",
        {29'b0, in_ready, host_wait, bus_oe}, 32'h4);
    rd_status("R11 R4 status after reset");

    // empty reads
    rd_data("R7 empty read returns 0");
    rd_status("R7 R4 underrun flag");
    rd_status("R6 flags cleared by status read");

    // byte order and deferred free
    push_word(32'h1122_3344);
    push_word(32'hA5B6_C7D8);
    rd_status("R4 count two");
    for (int i = 0; i < 3; i++) rd_data("R2 byte order");
    rd_status("R2 count held until last byte");
    rd_data("R2 last byte");
    rd_status("R2 count after free");
    for (int i = 0; i < 4; i++) rd_data("R2 second word");

    // fill, overflow, drop
    for (int i = 0; i < 4; i++) push_word(32'h0102_0304 + 32'h1010_1010 * i);
    rd_status("R4 full status");
    push_word(32'hDEAD_BEEF);
    rd_status("R5 overflow flags");
    rd_status("R6 lost cleared, overflow kept");
    for (int i = 0; i < 16; i++) rd_data("R5 stored words unchanged");
    rd_status("R4 empty after drain");

    // test register and select
    wr_addr(8'h01);
    rd_data("R9 reset test value inverted");
    push_word(32'h0000_00C3);
    wr_data(8'h5A, "R9 test write");
    rd_data("R9 inverted readback");
    rd_data("R9 repeat readback");
    rd_status("R9 buffer untouched");
    wr_addr(8'h00);
    wr_data(8'h77, "R10 write ignored");
    rd_status("R10 count unchanged");
    for (int i = 0; i < 4; i++) rd_data("R10 R8 word intact");
    rd_status("R8 final status");

    finish_run();
  end
endmodule